// File: doc/BRIEF.md
# Grouped-Priority Nested Interrupt Controller

This block gathers interrupt events from up to sixteen source positions, twelve of which are populated, and keeps one pending flag per source in two 8-bit flag registers. Software can read and write these registers. Writing a 1 raises a software-triggered request, and writing a 0 clears a pending request. Priority is not set per source. Each source belongs to one of six groups, and each group takes a 2-bit level. Bit 0 of every group's level sits in one priority register and bit 1 in another.

From the flags that are enabled and pending, the controller picks the one with the highest level. When levels tie, the lowest source index wins. It raises a request and presents the winner's index as the vector. A 4-bit in-service record keeps one bit per level. When the CPU accepts a vector, the winner's level is added to the record. A return-from-interrupt removes the highest recorded level. A new request is shown only when its level is strictly above the highest level in service. The four timer sources drop their flags by themselves when they are vectored. Every other source waits for software to clear it.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset, every flag, enable, priority bit and the global enable are 0, every register reads 0 and irq_o is low.
- R2: The register addresses are as follows. Address 0 holds the flags of sources 0 to 7 and address 1 the flags of sources 8 to 15. Addresses 2 and 3 hold the per-source enables in the same bit layout. Address 4 holds level bit 0 of group g at bit g, and address 5 holds level bit 1 of group g at bit g. Address 6 holds the global enable at bit 0. Unpopulated sources (6, 13, 14, 15), priority bits 7:6 and control bits 7:1 always read 0, and writes to them have no effect.
- R3: A pulse on evt_i[i] for a populated source i makes flag i read 1 from the next cycle on. Pulses on unpopulated positions have no effect.
- R4: A register write stores its value as the new flags: a 1 makes the source pending and can raise a request, and a 0 clears it. When an event sets a flag in the same cycle that software clears it, the flag ends up set.
- R5: Source i belongs to group i mod 6. Its level is {level bit 1, level bit 0} of that group, so 3 is the highest level.
- R6: A source can request only if its flag, its enable and the global enable are all 1. A disabled source still latches its flag, and that flag can be read.
- R7: Among the sources that can request, the one with the highest level wins, and a tie goes to the lowest index. vec_o gives the winner's source index.
- R8: Asserting ack_i while irq_o is high adds the winner's level to the in-service record. Asserting ack_i while irq_o is low changes nothing.
- R9: While any level is in service, irq_o is high only when the winner's level is strictly greater than the highest level in service.
- R10: Asserting reti_i removes the highest level in service. The next lower recorded level, if there is one, becomes the running level.
- R11: Flags of the timer sources 1 to 4 clear when they are acknowledged. Flags of all other sources stay pending after acknowledge until software clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| evt_i | input | 16 | Single-cycle event pulses, one per source position |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 4 | Index of the winning source |
| ack_i | input | 1 | CPU vectors to the presented request |
| reti_i | input | 1 | CPU returns from the current handler |

## Verification
Two situations can land in the same cycle. In the first, a hardware event arrives in the cycle that software writes a 0 to the same flag register. The bench drives both in one cycle and then expects the flag to read back as 1. In the second, acknowledges and returns interleave against a stack that holds two levels. The bench pends requests at equal, higher and lower levels and lets one return expose the next lower level. It then judges irq_o, vec_o and the flag readback against the levels worked out from the group mapping.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
    localparam int unsigned DW    = 8;
    localparam int unsigned AW    = 3;
    localparam int unsigned NSRC  = 2 * DW;
    localparam int unsigned NGRP  = 6;
    localparam int unsigned LVLW  = 2;
    localparam int unsigned NLVL  = 1 << LVLW;
    localparam int unsigned IDXW  = $clog2(NSRC);

    localparam logic [NSRC-1:0] SRC_VALID = 16'h1FBF;
    localparam logic [NSRC-1:0] SRC_AUTOC = 16'h001E;

    localparam logic [AW-1:0] ADR_FLG_LO = 3'd0;
    localparam logic [AW-1:0] ADR_FLG_HI = 3'd1;
    localparam logic [AW-1:0] ADR_ENA_LO = 3'd2;
    localparam logic [AW-1:0] ADR_ENA_HI = 3'd3;
    localparam logic [AW-1:0] ADR_PRI_B0 = 3'd4;
    localparam logic [AW-1:0] ADR_PRI_B1 = 3'd5;
    localparam logic [AW-1:0] ADR_CTRL   = 3'd6;
endpackage

// File: rtl/irqc_regs.sv
`timescale 1ns/1ps
module irqc_regs #(
    parameter int unsigned DW    = irqc_pkg::DW,
    parameter int unsigned AW    = irqc_pkg::AW,
    parameter int unsigned NGRP  = irqc_pkg::NGRP,
    parameter int unsigned IDXW  = irqc_pkg::IDXW,
    parameter logic [2*DW-1:0] VALID = irqc_pkg::SRC_VALID,
    parameter logic [2*DW-1:0] AUTOC = irqc_pkg::SRC_AUTOC
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o,
    input  logic [2*DW-1:0]  evt_i,
    input  logic             clr_i,
    input  logic [IDXW-1:0]  clr_idx_i,
    output logic [2*DW-1:0]  flag_o,
    output logic [2*DW-1:0]  en_o,
    output logic [NGRP-1:0]  pb0_o,
    output logic [NGRP-1:0]  pb1_o,
    output logic             gie_o
);
    import irqc_pkg::*;
    localparam int unsigned NS = 2 * DW;

    typedef struct packed {
        logic [NS-1:0]   flag;
        logic [NS-1:0]   en;
        logic [NGRP-1:0] pb0;
        logic [NGRP-1:0] pb1;
        logic            gie;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we_i) begin
            case (addr_i)
                ADR_FLG_LO: r_d.flag[DW-1:0]  = wdata_i & VALID[DW-1:0];
                ADR_FLG_HI: r_d.flag[NS-1:DW] = wdata_i & VALID[NS-1:DW];
                ADR_ENA_LO: r_d.en[DW-1:0]    = wdata_i & VALID[DW-1:0];
                ADR_ENA_HI: r_d.en[NS-1:DW]   = wdata_i & VALID[NS-1:DW];
                ADR_PRI_B0: r_d.pb0           = wdata_i[NGRP-1:0];
                ADR_PRI_B1: r_d.pb1           = wdata_i[NGRP-1:0];
                ADR_CTRL:   r_d.gie           = wdata_i[0];
                default: ;
            endcase
        end
        // vectored timer flags drop themselves
        if (clr_i && AUTOC[clr_idx_i]) begin
            r_d.flag[clr_idx_i] = 1'b0;
        end
        // hardware events override any clear in the same cycle
        r_d.flag = r_d.flag | (evt_i & VALID);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADR_FLG_LO: rdata_o = r_q.flag[DW-1:0];
            ADR_FLG_HI: rdata_o = r_q.flag[NS-1:DW];
            ADR_ENA_LO: rdata_o = r_q.en[DW-1:0];
            ADR_ENA_HI: rdata_o = r_q.en[NS-1:DW];
            ADR_PRI_B0: rdata_o = {{(DW-NGRP){1'b0}}, r_q.pb0};
            ADR_PRI_B1: rdata_o = {{(DW-NGRP){1'b0}}, r_q.pb1};
            ADR_CTRL:   rdata_o = {{(DW-1){1'b0}}, r_q.gie};
            default:    rdata_o = '0;
        endcase
    end

    assign flag_o = r_q.flag;
    assign en_o   = r_q.en;
    assign pb0_o  = r_q.pb0;
    assign pb1_o  = r_q.pb1;
    assign gie_o  = r_q.gie;

    // R3
    evt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(evt_i & VALID)) |=> ((r_q.flag & $past(evt_i & VALID)) == $past(evt_i & VALID)));

    // R11
    auto_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && AUTOC[clr_idx_i] && !evt_i[clr_idx_i] && !we_i) |=> !r_q.flag[$past(clr_idx_i)]);

    // R2
    rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((r_q.flag | r_q.en) & ~VALID) == '0);
endmodule

// File: rtl/irqc_arb.sv
`timescale 1ns/1ps
module irqc_arb #(
    parameter int unsigned NSRC = irqc_pkg::NSRC,
    parameter int unsigned NGRP = irqc_pkg::NGRP,
    parameter int unsigned LVLW = irqc_pkg::LVLW,
    parameter int unsigned IDXW = irqc_pkg::IDXW
) (
    input  logic [NSRC-1:0] flag_i,
    input  logic [NSRC-1:0] en_i,
    input  logic [NGRP-1:0] pb0_i,
    input  logic [NGRP-1:0] pb1_i,
    input  logic            gie_i,
    output logic            req_o,
    output logic [IDXW-1:0] idx_o,
    output logic [LVLW-1:0] lvl_o
);
    logic [NSRC-1:0] live;
    logic [LVLW-1:0] src_lvl [NSRC];

    assign live = flag_i & en_i & {NSRC{gie_i}};

    for (genvar i = 0; i < NSRC; i++) begin : g_lvl
        localparam int unsigned GRP = i % NGRP;
        assign src_lvl[i] = {pb1_i[GRP], pb0_i[GRP]};
    end

    // ascending scan; only a strictly higher level displaces the holder
    always_comb begin
        req_o = 1'b0;
        idx_o = '0;
        lvl_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (live[i] && (!req_o || src_lvl[i] > lvl_o)) begin
                req_o = 1'b1;
                idx_o = IDXW'(i);
                lvl_o = src_lvl[i];
            end
        end
    end
endmodule

// File: rtl/irqc_nest.sv
`timescale 1ns/1ps
module irqc_nest #(
    parameter int unsigned LVLW = irqc_pkg::LVLW,
    parameter int unsigned NLVL = irqc_pkg::NLVL
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            req_i,
    input  logic [LVLW-1:0] lvl_i,
    input  logic            ack_i,
    input  logic            reti_i,
    output logic            irq_o,
    output logic            take_o
);
    typedef struct packed {
        logic [NLVL-1:0] isr;
    } nest_t;

    nest_t n_d, n_q;
    logic            busy;
    logic [LVLW-1:0] run_lvl;

    always_comb begin
        busy    = |n_q.isr;
        run_lvl = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (n_q.isr[l]) run_lvl = LVLW'(l);
        end
    end

    assign irq_o  = req_i && (!busy || lvl_i > run_lvl);
    assign take_o = ack_i && irq_o;

    always_comb begin
        n_d = n_q;
        if (reti_i && busy) n_d.isr[run_lvl] = 1'b0;
        if (take_o)         n_d.isr[lvl_i]   = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) n_q <= '0;
        else         n_q <= n_d;
    end

    // R8
    take_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_o |=> n_q.isr[$past(lvl_i)]);

    // R8
    ack_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && !irq_o && !reti_i) |=> $stable(n_q.isr));

    // R9
    no_same_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_o |-> ((n_q.isr >> lvl_i) == '0));

    // R10
    reti_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reti_i && busy && !take_o) |=> ($countones(n_q.isr) + 1 == $countones($past(n_q.isr))));
endmodule

// File: rtl/grp_irq_ctrl.sv
`timescale 1ns/1ps
module grp_irq_ctrl
    import irqc_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            reg_we_i,
    input  logic [AW-1:0]   reg_addr_i,
    input  logic [DW-1:0]   reg_wdata_i,
    output logic [DW-1:0]   reg_rdata_o,
    input  logic [NSRC-1:0] evt_i,
    output logic            irq_o,
    output logic [IDXW-1:0] vec_o,
    input  logic            ack_i,
    input  logic            reti_i
);
    logic [NSRC-1:0] flag, en;
    logic [NGRP-1:0] pb0, pb1;
    logic            gie, req, take;
    logic [IDXW-1:0] win_idx;
    logic [LVLW-1:0] win_lvl;

    irqc_regs u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (reg_we_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .rdata_o   (reg_rdata_o),
        .evt_i     (evt_i),
        .clr_i     (take),
        .clr_idx_i (win_idx),
        .flag_o    (flag),
        .en_o      (en),
        .pb0_o     (pb0),
        .pb1_o     (pb1),
        .gie_o     (gie)
    );

    irqc_arb u_arb (
        .flag_i (flag),
        .en_i   (en),
        .pb0_i  (pb0),
        .pb1_i  (pb1),
        .gie_i  (gie),
        .req_o  (req),
        .idx_o  (win_idx),
        .lvl_o  (win_lvl)
    );

    irqc_nest u_nest (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .req_i  (req),
        .lvl_i  (win_lvl),
        .ack_i  (ack_i),
        .reti_i (reti_i),
        .irq_o  (irq_o),
        .take_o (take)
    );

    assign vec_o = win_idx;

    // R6
    req_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (flag[vec_o] && en[vec_o] && gie));
endmodule

// File: tb/grp_irq_ctrl_bench.sv
`timescale 1ns/1ps
module grp_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wd = '0;
    logic [7:0]  rdata;
    logic [15:0] evt = '0;
    logic        irq;
    logic [3:0]  vec;
    logic        ack = 1'b0;
    logic        reti = 1'b0;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    grp_irq_ctrl u_grp_irq_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wd), .reg_rdata_o(rdata), .evt_i(evt), .irq_o(irq),
        .vec_o(vec), .ack_i(ack), .reti_i(reti)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); we = 1'b1; addr = a; wd = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk); addr = a; #1;
        chk(req, rdata, exp);
    endtask

    task automatic pulse_evt(input logic [15:0] v);
        @(negedge clk); evt = v;
        @(negedge clk); evt = '0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic pulse_reti();
        @(negedge clk); reti = 1'b1;
        @(negedge clk); reti = 1'b0;
    endtask

    task automatic see(input string req, input logic exp_irq, input logic [3:0] exp_vec);
        @(negedge clk); #1;
        chk(req, irq, exp_irq);
        if (exp_irq) chk(req, vec, exp_vec);
    endtask

    task automatic clear_all();
        for (int a = 0; a < 7; a++) wr(a[2:0], 8'h00);
    endtask

    task automatic t_reset();
        for (int a = 0; a < 8; a++) rd_chk("R1 reset read", a[2:0], 8'h00);
        see("R1 reset irq", 1'b0, 4'd0);
    endtask

    task automatic t_regmap();
        wr(3'd0, 8'hFF); rd_chk("R2 flags lo", 3'd0, 8'hBF);
        wr(3'd1, 8'hFF); rd_chk("R2 flags hi", 3'd1, 8'h1F);
        wr(3'd2, 8'hFF); rd_chk("R2 enable lo", 3'd2, 8'hBF);
        wr(3'd3, 8'hFF); rd_chk("R2 enable hi", 3'd3, 8'h1F);
        wr(3'd4, 8'hFF); rd_chk("R2 level b0", 3'd4, 8'h3F);
        wr(3'd5, 8'hFF); rd_chk("R2 level b1", 3'd5, 8'h3F);
        wr(3'd6, 8'hFF); rd_chk("R2 control", 3'd6, 8'h01);
        clear_all();
    endtask

    task automatic t_event();
        pulse_evt(16'hFFFF);
        rd_chk("R3 event lo", 3'd0, 8'hBF);
        rd_chk("R3 event hi", 3'd1, 8'h1F);
        wr(3'd0, 8'h00); wr(3'd1, 8'h00);
        rd_chk("R4 sw clear", 3'd0, 8'h00);
    endtask

    task automatic t_gate();
        wr(3'd2, 8'hFF);
        pulse_evt(16'h0020);
        see("R6 no global enable", 1'b0, 4'd0);
        rd_chk("R6 flag latched", 3'd0, 8'h20);
        wr(3'd2, 8'h00); wr(3'd6, 8'h01);
        see("R6 source disabled", 1'b0, 4'd0);
        rd_chk("R6 disabled still latched", 3'd0, 8'h20);
        wr(3'd2, 8'h20);
        see("R6 enabled request", 1'b1, 4'd5);
        clear_all();
    endtask

    task automatic t_select();
        wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd6, 8'h01);
        wr(3'd0, 8'h0C); wr(3'd1, 8'h02);          // sources 2, 3, 9
        see("R7 tie lowest index", 1'b1, 4'd2);
        wr(3'd5, 8'h08);                           // group 3 level 2
        see("R7 higher level wins", 1'b1, 4'd3);
        wr(3'd0, 8'h00); wr(3'd1, 8'h12);          // sources 9, 12
        see("R5 group of source 9", 1'b1, 4'd9);
        wr(3'd4, 8'h01); wr(3'd5, 8'h09);          // group0=3, group3=2
        see("R5 group of source 12", 1'b1, 4'd12);
        clear_all();
    endtask

    task automatic t_nest();
        wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd6, 8'h01);
        wr(3'd4, 8'h12); wr(3'd5, 8'h14);          // g1=1, g2=2, g4=3
        wr(3'd0, 8'h80);                           // source 7, level 1
        see("R4 software trigger", 1'b1, 4'd7);
        pulse_ack();
        see("R9 same level blocked", 1'b0, 4'd0);
        rd_chk("R11 non-timer stays", 3'd0, 8'h80);
        pulse_evt(16'h0100);                       // source 8, level 2
        see("R9 higher preempts", 1'b1, 4'd8);
        pulse_ack();
        see("R8 level 2 in service", 1'b0, 4'd0);
        pulse_evt(16'h0400);                       // source 10, level 3
        see("R9 level 3 over 2", 1'b1, 4'd10);
        wr(3'd1, 8'h01);
        see("R4 cleared request", 1'b0, 4'd0);
        pulse_evt(16'h0004);                       // source 2, level 2
        see("R9 equal level blocked", 1'b0, 4'd0);
        pulse_reti();
        see("R10 pop exposes level 1", 1'b1, 4'd2);
        pulse_ack();
        rd_chk("R11 timer autoclear", 3'd0, 8'h80);
        see("R8 acked level 2 holds", 1'b0, 4'd0);
        pulse_reti();
        see("R10 back to level 1", 1'b1, 4'd8);
        pulse_reti();
        see("R10 stack empty", 1'b1, 4'd8);
        clear_all();
    endtask

    task automatic t_race();
        wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd6, 8'h01);
        @(negedge clk); we = 1'b1; addr = 3'd0; wd = 8'h00; evt = 16'h0020;
        @(negedge clk); we = 1'b0; evt = '0;
        rd_chk("R4 set beats clear", 3'd0, 8'h20);
        wr(3'd0, 8'h00);
        see("R8 idle before ack", 1'b0, 4'd0);
        pulse_ack();
        wr(3'd1, 8'h08);                           // source 11, level 0
        see("R8 idle ack ignored", 1'b1, 4'd11);
        pulse_evt(16'hE040);                       // unpopulated only
        rd_chk("R3 reserved lo ignored", 3'd0, 8'h00);
        rd_chk("R3 reserved hi ignored", 3'd1, 8'h08);
        clear_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_event();
        t_gate();
        t_select();
        t_nest();
        t_race();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule